// File: doc/BRIEF.md
# SDRAM Burst Read Sequencer

This block runs a single eight-word line fill from a synchronous DRAM attached on a 32-bit data bus. A caller presents a bank, a row and a column together with a request strobe. While idle, the sequencer accepts that request. It then opens the row, issues the column command or commands, and captures the eight returned words. Each captured word is handed on with a one-cycle valid strobe. Finally it keeps the command pins quiet for a programmable precharge wait and reports completion.

The column phase has two variants, chosen by a burst-length select bit. With four-word bursts, a plain read is issued first. Four cycles later a second read with auto-precharge follows, aimed four columns further on. With eight-word bursts, a single read with auto-precharge covers all eight beats. The memory returns its first word three cycles after the first column command. The sequencer samples one word on each of the next eight rising edges.

The state machine has six states. IDLE moves to ACT when a request is accepted. ACT always moves to ROWWAIT. ROWWAIT always moves to COL. COL moves to DATA after its third cycle. DATA moves to PRE after its eighth cycle. PRE returns to IDLE after the programmed number of precharge-wait cycles.

Top module: `sdram_burst_rd`

## Requirements
- R1: After reset the block is idle: busy and done are low, rd_valid is low, DQM is high, CKE is high and the command pins carry NOP.
- R2: A request seen while idle leads, in the next cycle, to ACTIVATE (CS#,RAS#,CAS#,WE# = 0,0,1,1) with the request's bank and row. The following cycle is a NOP (0,1,1,1).
- R3: With cfg_bl8 = 0, a READ (0,1,0,1) goes out two cycles after ACTIVATE with address bit 10 low and the request column in the low address bits. A second READ follows exactly four cycles later with bit 10 high and the column plus four, modulo the column range.
- R4: With cfg_bl8 = 1, exactly one READ goes out, two cycles after ACTIVATE. It carries bit 10 high and the request column, and no other column command is issued.
- R5: The sequencer samples sd_dq_in at the rising edges ending the eight data cycles. The first data cycle is three cycles after the first READ. Each sampled word appears on rd_data with rd_valid high in the cycle after its sampling edge.
- R6: DQM is low during the eight data cycles and high in every other cycle.
- R7: After the last data cycle, the block spends cfg_tpc + 1 cycles (1 to 8) in precharge wait. Every one of those cycles carries NOP.
- R8: busy is high from the cycle after acceptance through the last precharge-wait cycle. done is high in that last cycle only, and busy is low in the cycle after it.
- R9: A request raised while busy is ignored. It causes no extra ACTIVATE and does not change the bank, row or column used by the running sequence.
- R10: cfg_bl8 and cfg_tpc are sampled when a request is accepted. Changing them during a sequence has no effect on that sequence.
- R11: CKE is high in every cycle. Every cycle other than ACTIVATE and READ carries NOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Line-fill request |
| req_bank | input | 2 | Bank address of the request |
| req_row | input | 13 | Row address of the request |
| req_col | input | 9 | Starting column of the request |
| cfg_bl8 | input | 1 | 1 = one eight-word burst, 0 = two four-word bursts |
| cfg_tpc | input | 3 | Precharge-wait length minus one |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Last precharge-wait cycle |
| sd_cke | output | 1 | SDRAM clock enable |
| sd_cs_n | output | 1 | SDRAM chip select, active low |
| sd_ras_n | output | 1 | SDRAM row strobe, active low |
| sd_cas_n | output | 1 | SDRAM column strobe, active low |
| sd_we_n | output | 1 | SDRAM write enable, active low |
| sd_ba | output | 2 | SDRAM bank address |
| sd_addr | output | 13 | SDRAM address bus, bit 10 selects auto-precharge |
| sd_dqm | output | 1 | SDRAM data mask |
| sd_dq_in | input | 32 | Read data from the SDRAM |
| rd_data | output | 32 | Captured read word |
| rd_valid | output | 1 | rd_data holds a new word |

## Verification
Requests are run in both burst modes and at the shortest, longest and intermediate precharge waits. This separates a misplaced second READ, a wrong auto-precharge bit or an off-by-one in the wait. A start column near the top of the column range shows whether the second column address wraps. Requests and configuration changes injected mid-sequence, along with a request held high across several sequences, show whether anything is sampled outside the idle state. The bench's memory model answers the commands actually seen on the pins. As a result, data words tagged by bank, row and column expose any mistiming of the capture edges.

// File: rtl/sdrd_pkg.sv
package sdrd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ACT,
        ST_ROWWAIT,
        ST_COL,
        ST_DATA,
        ST_PRE
    } sdrd_state_t;

    typedef enum logic [1:0] {
        CMD_NOP,
        CMD_ACT,
        CMD_RD
    } sdrd_cmd_t;

    localparam int COL_CYCLES  = 3;   // Tc1..Tc3 before first data cycle
    localparam int DATA_BEATS  = 8;
    localparam int SECOND_RD   = 1;   // data-phase index of second READ (Tc1 + 4)
    localparam int COL_STRIDE  = 4;

endpackage

// File: rtl/sdrd_step_cnt.sv
module sdrd_step_cnt #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    output logic [W-1:0] cnt
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (clr)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

endmodule

// File: rtl/sdrd_cmd_enc.sv
module sdrd_cmd_enc
    import sdrd_pkg::*;
(
    input  sdrd_cmd_t cmd,
    output logic      cke,
    output logic      cs_n,
    output logic      ras_n,
    output logic      cas_n,
    output logic      we_n
);

    always_comb begin
        cke = 1'b1;
        cs_n = 1'b0;
        unique case (cmd)
            CMD_ACT: {ras_n, cas_n, we_n} = 3'b011;
            CMD_RD:  {ras_n, cas_n, we_n} = 3'b101;
            default: {ras_n, cas_n, we_n} = 3'b111;
        endcase
    end

endmodule

// File: rtl/sdrd_capture.sv
module sdrd_capture #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout,
    output logic          valid
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dout  <= '0;
            valid <= 1'b0;
        end else begin
            valid <= en;
            if (en)
                dout <= din;
        end
    end

endmodule

// File: rtl/sdram_burst_rd.sv
module sdram_burst_rd
    import sdrd_pkg::*;
#(
    parameter int BANK_W = 2,
    parameter int ROW_W  = 13,
    parameter int COL_W  = 9,
    parameter int DQ_W   = 32,
    parameter int AP_BIT = 10,
    parameter int TPC_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [ROW_W-1:0]  req_row,
    input  logic [COL_W-1:0]  req_col,
    input  logic              cfg_bl8,
    input  logic [TPC_W-1:0]  cfg_tpc,
    output logic              busy,
    output logic              done,
    output logic              sd_cke,
    output logic              sd_cs_n,
    output logic              sd_ras_n,
    output logic              sd_cas_n,
    output logic              sd_we_n,
    output logic [BANK_W-1:0] sd_ba,
    output logic [ROW_W-1:0]  sd_addr,
    output logic              sd_dqm,
    input  logic [DQ_W-1:0]   sd_dq_in,
    output logic [DQ_W-1:0]   rd_data,
    output logic              rd_valid
);

    localparam int CNT_W = (TPC_W >= 3) ? TPC_W + 1 : 4;
    localparam logic [CNT_W-1:0] COL_LAST  = CNT_W'(COL_CYCLES - 1);
    localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(DATA_BEATS - 1);
    localparam logic [CNT_W-1:0] RD2_IDX   = CNT_W'(SECOND_RD);

    sdrd_state_t       state, state_n;
    sdrd_cmd_t         cmd;
    logic [CNT_W-1:0]  cnt;
    logic              ap;
    logic [COL_W-1:0]  col_sel;
    logic [BANK_W-1:0] bank_q;
    logic [ROW_W-1:0]  row_q;
    logic [COL_W-1:0]  col_q;
    logic              bl8_q;
    logic [TPC_W-1:0]  tpc_q;
    logic              accept;

    assign accept = (state == ST_IDLE) && req;

    // step counter restarts whenever the state changes
    sdrd_step_cnt #(.W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (state_n != state),
        .cnt   (cnt)
    );

    // next-state logic
    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE:    if (req) state_n = ST_ACT;
            ST_ACT:     state_n = ST_ROWWAIT;
            ST_ROWWAIT: state_n = ST_COL;
            ST_COL:     if (cnt == COL_LAST) state_n = ST_DATA;
            ST_DATA:    if (cnt == DATA_LAST) state_n = ST_PRE;
            ST_PRE:     if (cnt == CNT_W'(tpc_q)) state_n = ST_IDLE;
            default:    state_n = ST_IDLE;
        endcase
    end

    // state register and request capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            bank_q <= '0;
            row_q  <= '0;
            col_q  <= '0;
            bl8_q  <= 1'b0;
            tpc_q  <= '0;
        end else begin
            state <= state_n;
            if (accept) begin
                bank_q <= req_bank;
                row_q  <= req_row;
                col_q  <= req_col;
                bl8_q  <= cfg_bl8;
                tpc_q  <= cfg_tpc;
            end
        end
    end

    // outputs from state
    always_comb begin
        cmd     = CMD_NOP;
        ap      = 1'b0;
        col_sel = col_q;
        sd_addr = '0;
        sd_ba   = bank_q;
        sd_dqm  = 1'b1;
        busy    = 1'b1;
        done    = 1'b0;
        unique case (state)
            ST_IDLE: busy = 1'b0;
            ST_ACT: begin
                cmd     = CMD_ACT;
                sd_addr = row_q;
            end
            ST_ROWWAIT: ;
            ST_COL: begin
                if (cnt == '0) begin
                    cmd = CMD_RD;
                    ap  = bl8_q;
                end
            end
            ST_DATA: begin
                sd_dqm = 1'b0;
                if (!bl8_q && cnt == RD2_IDX) begin
                    cmd     = CMD_RD;
                    ap      = 1'b1;
                    col_sel = col_q + COL_W'(COL_STRIDE);
                end
            end
            ST_PRE: done = (cnt == CNT_W'(tpc_q));
            default: busy = 1'b0;
        endcase
        if (cmd == CMD_RD) begin
            sd_addr[COL_W-1:0] = col_sel;
            sd_addr[AP_BIT]    = ap;
        end
    end

    sdrd_cmd_enc u_enc (
        .cmd   (cmd),
        .cke   (sd_cke),
        .cs_n  (sd_cs_n),
        .ras_n (sd_ras_n),
        .cas_n (sd_cas_n),
        .we_n  (sd_we_n)
    );

    sdrd_capture #(.DW(DQ_W)) u_cap (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (state == ST_DATA),
        .din   (sd_dq_in),
        .dout  (rd_data),
        .valid (rd_valid)
    );

    // pin-level command views for checking
    logic pin_act, pin_rd, pin_nop;
    assign pin_act = !sd_cs_n && !sd_ras_n &&  sd_cas_n &&  sd_we_n;
    assign pin_rd  = !sd_cs_n &&  sd_ras_n && !sd_cas_n &&  sd_we_n;
    assign pin_nop = !sd_cs_n &&  sd_ras_n &&  sd_cas_n &&  sd_we_n;

    AST_ACT_THEN_NOP: assert property (@(posedge clk) disable iff (!rst_n)
        pin_act |=> pin_nop); // R2

    AST_RDA_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_rd && sd_addr[AP_BIT] && !bl8_q) |-> $past(pin_rd && !sd_addr[AP_BIT], 4)); // R3

    AST_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DATA) |=> (rd_valid && rd_data == $past(sd_dq_in))); // R5

    AST_PRE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PRE) |-> (pin_nop && sd_cke)); // R7

    AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy); // R8

    AST_DONE_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy); // R8

    AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && req) |=> !pin_act); // R9

endmodule

// File: tb/tb_sdram_burst_rd.sv
module tb_sdram_burst_rd;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic [1:0]  req_bank = '0;
    logic [12:0] req_row = '0;
    logic [8:0]  req_col = '0;
    logic        cfg_bl8 = 1'b0;
    logic [2:0]  cfg_tpc = '0;
    logic [31:0] sd_dq_in = '0;
    logic        busy, done, sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_dqm, rd_valid;
    logic [1:0]  sd_ba;
    logic [12:0] sd_addr;
    logic [31:0] rd_data;

    always #5 clk = ~clk;

    sdram_burst_rd dut (
        .clk(clk), .rst_n(rst_n), .req(req), .req_bank(req_bank), .req_row(req_row),
        .req_col(req_col), .cfg_bl8(cfg_bl8), .cfg_tpc(cfg_tpc), .busy(busy), .done(done),
        .sd_cke(sd_cke), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n),
        .sd_we_n(sd_we_n), .sd_ba(sd_ba), .sd_addr(sd_addr), .sd_dqm(sd_dqm),
        .sd_dq_in(sd_dq_in), .rd_data(rd_data), .rd_valid(rd_valid)
    );

    int vectors = 0;
    int fails = 0;
    int cyc = 0;
    int ph = 0;          // cycles since acceptance, 0 = idle
    int accepts = 0;
    int acts_seen = 0;
    logic [1:0]  m_bank;
    logic [12:0] m_row;
    logic [8:0]  m_col;
    bit          m_bl8;
    int          m_tpc;
    logic [12:0] mem_row = '0;
    logic [31:0] sched [int];

    function automatic logic [31:0] word_of(logic [1:0] b, logic [12:0] r, logic [8:0] c);
        return {2'b10, 6'h2B, b, r, c};
    endfunction

    // reference timeline: advanced on each rising edge
    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            ph = 0;
        end else if (ph != 0) begin
            ph++;
            if (ph > 14 + m_tpc) ph = 0;
        end else if (req) begin
            ph = 1;
            accepts++;
            m_bank = req_bank; m_row = req_row; m_col = req_col;
            m_bl8 = cfg_bl8; m_tpc = int'(cfg_tpc);
        end
        if (cyc > 20000) begin
            fails++;
            $display("FAIL watchdog: run did not finish, actual cycle %0d expected < 20000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    // compare every cycle, then act as the memory
    always @(negedge clk) begin
        int  e_cmd, a_cmd, rd2;
        bit  e_ap, e_busy, e_done, e_dqm, e_valid, bad;
        logic [8:0]  e_col;
        logic [31:0] e_data;
        string tag;
        vectors++;
        bad = 0;
        rd2 = m_bl8 ? -1 : 7;
        e_cmd = 0; e_ap = 0; e_col = m_col;
        if (ph == 1) e_cmd = 1;
        if (ph == 3) begin e_cmd = 2; e_ap = m_bl8; end
        if (ph == rd2) begin e_cmd = 2; e_ap = 1; e_col = m_col + 9'd4; end
        e_busy  = (ph != 0);
        e_done  = (ph != 0) && (ph == 14 + m_tpc);
        e_dqm   = !(ph >= 6 && ph <= 13);
        e_valid = (ph >= 7 && ph <= 14);
        e_data  = word_of(m_bank, m_row, m_col + 9'(ph - 7));
        case ({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n})
            4'b0011: a_cmd = 1;
            4'b0101: a_cmd = 2;
            4'b0111: a_cmd = 0;
            default: a_cmd = 3;
        endcase
        if (ph == 0) tag = "R1";
        else if (ph == 1 || ph == 2) tag = "R2";
        else if (ph >= 14) tag = "R7";
        else if (ph == 3 || ph == rd2) tag = m_bl8 ? "R4" : "R3";
        else tag = "R11";
        if (a_cmd != e_cmd) begin
            bad = 1;
            $display("FAIL %s cmd at ph %0d: actual %0d expected %0d", tag, ph, a_cmd, e_cmd);
        end
        if (sd_cke !== 1'b1) begin
            bad = 1;
            $display("FAIL R11 cke: actual %b expected 1", sd_cke);
        end
        if (e_cmd == 1 && (sd_ba !== m_bank || sd_addr !== m_row)) begin
            bad = 1;
            $display("FAIL R2 act addr: actual %h/%h expected %h/%h", sd_ba, sd_addr, m_bank, m_row);
        end
        if (e_cmd == 2 && (sd_ba !== m_bank || sd_addr[8:0] !== e_col || sd_addr[10] !== e_ap)) begin
            bad = 1;
            $display("FAIL %s read addr: actual ba %h col %h ap %b expected ba %h col %h ap %b",
                     tag, sd_ba, sd_addr[8:0], sd_addr[10], m_bank, e_col, e_ap);
        end
        if (sd_dqm !== e_dqm) begin
            bad = 1;
            $display("FAIL R6 dqm at ph %0d: actual %b expected %b", ph, sd_dqm, e_dqm);
        end
        if (busy !== e_busy || done !== e_done) begin
            bad = 1;
            $display("FAIL R8 busy/done at ph %0d: actual %b/%b expected %b/%b",
                     ph, busy, done, e_busy, e_done);
        end
        if (rd_valid !== e_valid) begin
            bad = 1;
            $display("FAIL R5 valid at ph %0d: actual %b expected %b", ph, rd_valid, e_valid);
        end else if (e_valid && rd_data !== e_data) begin
            bad = 1;
            $display("FAIL R5 data at ph %0d: actual %h expected %h", ph, rd_data, e_data);
        end
        if (bad) fails++;

        // memory model, CAS latency 3, reacting to the pins only
        if (a_cmd == 1) begin
            acts_seen++;
            mem_row = sd_addr;
        end
        if (a_cmd == 2) begin
            for (int k = 0; k < (m_bl8 ? 8 : 4); k++)
                sched[cyc + 3 + k] = word_of(sd_ba, mem_row, sd_addr[8:0] + 9'(k));
        end
        if (sched.exists(cyc)) begin
            sd_dq_in = sched[cyc];
            sched.delete(cyc);
        end else begin
            sd_dq_in = 32'h0BAD_0000 ^ 32'(cyc);
        end
    end

    task automatic run_req(input logic [1:0] b, input logic [12:0] r, input logic [8:0] c,
                           input bit bl8, input logic [2:0] tpc, input bit disturb);
        @(negedge clk);
        req = 1'b1; req_bank = b; req_row = r; req_col = c; cfg_bl8 = bl8; cfg_tpc = tpc;
        @(negedge clk);
        req = 1'b0;
        if (disturb) begin
            // R9 R10: new request fields and config while busy
            repeat (4) @(negedge clk);
            req = 1'b1; req_bank = ~b; req_row = ~r; req_col = c ^ 9'h0F3;
            cfg_bl8 = ~bl8; cfg_tpc = ~tpc;
            repeat (3) @(negedge clk);
            req = 1'b0;
        end
        do @(negedge clk); while (ph != 0);
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);     // R1 checked during and after reset
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        run_req(2'd1, 13'h0123, 9'h010, 1'b0, 3'd0, 1'b0);   // R3 shortest wait R7
        run_req(2'd2, 13'h1FFF, 9'h1F0, 1'b0, 3'd7, 1'b0);   // R3 longest wait R7
        run_req(2'd3, 13'h0AAA, 9'h055, 1'b1, 3'd3, 1'b0);   // R4
        run_req(2'd0, 13'h1555, 9'h1FE, 1'b0, 3'd5, 1'b0);   // R3 column wrap
        run_req(2'd1, 13'h0F0F, 9'h100, 1'b1, 3'd7, 1'b1);   // R9 R10
        run_req(2'd3, 13'h00FF, 9'h0C8, 1'b0, 3'd2, 1'b1);   // R9 R10
        // request held high across several sequences: only idle edges accept (R9)
        @(negedge clk);
        req = 1'b1; req_bank = 2'd2; req_row = 13'h1234; req_col = 9'h033;
        cfg_bl8 = 1'b1; cfg_tpc = 3'd0;
        repeat (60) @(negedge clk);
        req = 1'b0;
        do @(negedge clk); while (ph != 0);
        repeat (3) @(negedge clk);
        vectors++;
        if (acts_seen != accepts || accepts != 10) begin
            fails++;
            $display("FAIL R9 activate count: actual %0d expected %0d (model accepts %0d, want 10)",
                     acts_seen, accepts, accepts);
        end
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule